// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits on the path from a 12-bit converter to its output pins. On every sample strobe it forwards either the converter sample or a test word chosen by a 4-bit mode select. The menu holds fixed levels, words that alternate between two phases, a counting pattern in which each bit toggles at its own rate, two pseudo-random sequences, and two programmable user words. The user words can be played repeatedly or a single time, either as one word or as a pair taken in turn.

The output word and its valid flag are registered. A sample strobe at a clock edge updates the word at that edge and raises the valid flag for the following cycle. The pattern index restarts whenever the mode select or the user sequencing control differs from the value it had at the previous sample. The two pseudo-random generators each have their own synchronous reset. Each reset loads its generator with all ones and holds it there while it stays asserted.

Top module: `outpat_gen`

## Requirements
- R1: In mode 0, and for the unused codes 13 to 15, a sample updates out_data to in_data at that clock edge. After every edge, out_valid equals the smp_en that was sampled at that edge. Without a sample, out_data holds its value.
- R2: The constant modes produce fixed words: 1 gives 0x800, 2 gives 0xFFF, 3 gives 0x000, 10 gives 0xF00 and 11 gives 0x800.
- R3: Three modes alternate by pattern index, where index 0 is the first sample after a change of mode_sel or user_seq. Mode 4 gives 0xAAA at even indices and 0x555 at odd ones. Mode 7 gives 0x000 at even indices and 0xFFF at odd ones. Mode 9 gives 0x000 at even indices and 0x001 at odd ones.
- R4: Mode 12 outputs the pattern index modulo 4096, so bit k toggles every 2^k samples.
- R5: Mode 6 outputs the 9-bit generator for x^9+x^5+1, zero-extended, as {3'b000, state}. The state advances one step per sample in mode 6 by shifting left and taking bit8 XOR bit4 into bit 0. While pn_short_rst is high, the state is loaded with 0x1FF.
- R6: Mode 5 outputs bits 22 to 11 of the 23-bit generator for x^23+x^18+1. The state advances one step per sample in mode 5 by shifting left and taking bit22 XOR bit17 into bit 0. While pn_long_rst is high, the state is loaded with all ones.
- R7: In mode 8, user_seq 00 outputs user_a on every sample. user_seq 01 outputs user_a at even indices and user_b at odd ones.
- R8: In mode 8, user_seq 10 outputs user_a at index 0 and in_data afterwards. user_seq 11 outputs user_a at index 0, user_b at index 1, and in_data afterwards. This lasts until mode_sel or user_seq changes.
- R9: While rst_n is low, out_data is 0x000 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_en | input | 1 | Sample strobe |
| in_data | input | 12 | Converter sample |
| mode_sel | input | 4 | Pattern select |
| user_seq | input | 2 | User word sequencing |
| user_a | input | 12 | First user word |
| user_b | input | 12 | Second user word |
| pn_long_rst | input | 1 | Hold the 23-bit generator at its seed |
| pn_short_rst | input | 1 | Hold the 9-bit generator at its seed |
| out_data | output | 12 | Output word |
| out_valid | output | 1 | Output word updated by the last edge |

## Verification
Some properties are checked by assertions on every cycle:
- the valid flag tracks the strobe, and the word holds when no sample arrives;
- pass-through in mode 0 and after a one-shot user pattern has finished;
- the checkerboard alphabet;
- the seed load and hold of each generator, and that a generator never reaches the all-zero state.

Other behaviour can only be shown by the bench scenarios, which compare every sample against a model built from the requirements:
- the exact pseudo-random words;
- the restart of the pattern index on a change of mode;
- the order of the user words;
- the counting pattern.

// File: rtl/outpat_pkg.sv
package outpat_pkg;
  typedef enum logic [3:0] {
    M_NORMAL  = 4'd0,
    M_MID     = 4'd1,
    M_PFS     = 4'd2,
    M_NFS     = 4'd3,
    M_CHECK   = 4'd4,
    M_PN_LONG = 4'd5,
    M_PN_SHORT= 4'd6,
    M_WTOG    = 4'd7,
    M_USER    = 4'd8,
    M_BTOG    = 4'd9,
    M_SYNC    = 4'd10,
    M_ONEHI   = 4'd11,
    M_MIX     = 4'd12
  } mode_e;

  typedef enum logic [1:0] {
    U_REPEAT1 = 2'b00,
    U_REPEAT2 = 2'b01,
    U_ONCE1   = 2'b10,
    U_ONCE2   = 2'b11
  } useq_e;
endpackage

// File: rtl/outpat_lfsr.sv
module outpat_lfsr #(
  parameter int unsigned W   = 9,
  parameter int unsigned TAP = 4,
  parameter int unsigned DW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          adv,
  output logic [DW-1:0] word
);
  localparam logic [W-1:0] SEED = '1;

  logic [W-1:0] state;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[TAP]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (hold) state <= SEED;
    else if (adv)  state <= step(state);
  end

  generate
    if (W >= DW) begin : g_top
      assign word = state[W-1 -: DW];
    end else begin : g_ext
      assign word = DW'(state);
    end
  endgenerate

  // R5 R6
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> state == SEED);
  // R5 R6
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !adv) |=> $stable(state));
  // R5 R6
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/outpat_track.sv
module outpat_track #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic [3:0]    mode,
  input  logic [1:0]    useq,
  output logic          first,
  output logic [CW-1:0] idx,
  output logic [1:0]    once_cnt
);
  logic [3:0]    mode_q;
  logic [1:0]    useq_q;
  logic [CW-1:0] idx_q;
  logic [1:0]    cnt_q;

  assign first    = (mode != mode_q) || (useq != useq_q);
  assign idx      = first ? '0 : idx_q;
  assign once_cnt = first ? 2'd0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      useq_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (smp) begin
      mode_q <= mode;
      useq_q <= useq;
      idx_q  <= idx + 1'b1;
      cnt_q  <= (once_cnt == 2'd2) ? 2'd2 : once_cnt + 2'd1;
    end
  end

  // R8
  once_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3);
  // R3 R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(idx_q) && $stable(mode_q));
endmodule

// File: rtl/outpat_gen.sv
module outpat_gen #(
  parameter int unsigned DW       = 12,
  parameter int unsigned SHORT_W  = 9,
  parameter int unsigned SHORT_TAP= 4,
  parameter int unsigned LONG_W   = 23,
  parameter int unsigned LONG_TAP = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic [DW-1:0] in_data,
  input  logic [3:0]    mode_sel,
  input  logic [1:0]    user_seq,
  input  logic [DW-1:0] user_a,
  input  logic [DW-1:0] user_b,
  input  logic          pn_long_rst,
  input  logic          pn_short_rst,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  import outpat_pkg::*;

  localparam logic [DW-1:0] W_MID  = DW'(1) << (DW-1);
  localparam logic [DW-1:0] W_ONES = '1;
  localparam logic [DW-1:0] W_SYNC = ~(W_ONES >> (DW/3));

  mode_e         mode;
  useq_e         useq;
  logic          first;
  logic [DW-1:0] idx;
  logic [1:0]    once_cnt;
  logic          phase;
  logic          once_done;
  logic [DW-1:0] pn_short_word;
  logic [DW-1:0] pn_long_word;
  logic [DW-1:0] nxt;

  assign mode  = mode_e'(mode_sel);
  assign useq  = useq_e'(user_seq);
  assign phase = idx[0];
  assign once_done = (useq == U_ONCE1 && once_cnt >= 2'd1) ||
                     (useq == U_ONCE2 && once_cnt >= 2'd2);

  outpat_track #(.CW(DW)) i_track (
    .clk(clk), .rst_n(rst_n), .smp(smp_en), .mode(mode_sel), .useq(user_seq),
    .first(first), .idx(idx), .once_cnt(once_cnt)
  );

  outpat_lfsr #(.W(SHORT_W), .TAP(SHORT_TAP), .DW(DW)) i_pn_short (
    .clk(clk), .rst_n(rst_n), .hold(pn_short_rst),
    .adv(smp_en && mode == M_PN_SHORT), .word(pn_short_word)
  );

  outpat_lfsr #(.W(LONG_W), .TAP(LONG_TAP), .DW(DW)) i_pn_long (
    .clk(clk), .rst_n(rst_n), .hold(pn_long_rst),
    .adv(smp_en && mode == M_PN_LONG), .word(pn_long_word)
  );

  function automatic logic [DW-1:0] checker_word(input logic ph);
    logic [DW-1:0] w;
    for (int i = 0; i < int'(DW); i++) w[i] = (i % 2 == 1) ^ ph;
    return w;
  endfunction

  function automatic logic [DW-1:0] user_word(input useq_e s, input logic ph,
                                               input logic done,
                                               input logic [DW-1:0] a,
                                               input logic [DW-1:0] b,
                                               input logic [DW-1:0] d);
    if (done)       return d;
    if (s[0] && ph) return b;
    return a;
  endfunction

  always_comb begin
    case (mode)
      M_MID:      nxt = W_MID;
      M_PFS:      nxt = W_ONES;
      M_NFS:      nxt = '0;
      M_CHECK:    nxt = checker_word(phase);
      M_PN_LONG:  nxt = pn_long_word;
      M_PN_SHORT: nxt = pn_short_word;
      M_WTOG:     nxt = phase ? W_ONES : '0;
      M_USER:     nxt = user_word(useq, phase, once_done, user_a, user_b, in_data);
      M_BTOG:     nxt = DW'(phase);
      M_SYNC:     nxt = W_SYNC;
      M_ONEHI:    nxt = W_MID;
      M_MIX:      nxt = idx;
      default:    nxt = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= smp_en;
      if (smp_en) out_data <= nxt;
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |=> out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !out_valid && $stable(out_data));
  // R1
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && mode_sel == 4'd0) |=> out_data == $past(in_data));
  // R8
  once_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && mode == M_USER && once_done) |=> out_data == $past(in_data));
  // R3
  checker_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && mode == M_CHECK) |=> (out_data == 12'hAAA || out_data == 12'h555));
  // R3
  first_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && first && mode == M_CHECK) |=> out_data == 12'hAAA);
endmodule

// File: tb/test_outpat_gen.sv
module test_outpat_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_en = 1'b0;
  logic [11:0] in_data = '0;
  logic [3:0]  mode_sel = '0;
  logic [1:0]  user_seq = '0;
  logic [11:0] user_a = '0;
  logic [11:0] user_b = '0;
  logic        pn_long_rst = 1'b0;
  logic        pn_short_rst = 1'b0;
  logic [11:0] out_data;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  logic [3:0]  m_mode = '0;
  logic [1:0]  m_seq = '0;
  int          m_idx = 0;
  logic [8:0]  m_pn9 = 9'h1FF;
  logic [22:0] m_pn23 = 23'h7FFFFF;
  logic [11:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  outpat_gen i_outpat_gen (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .in_data(in_data),
    .mode_sel(mode_sel), .user_seq(user_seq), .user_a(user_a), .user_b(user_b),
    .pn_long_rst(pn_long_rst), .pn_short_rst(pn_short_rst),
    .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [8:0] pn9_next(input logic [8:0] s);
    logic fb = s[8] ^ s[4];
    return (s << 1) | 9'(fb);
  endfunction

  function automatic logic [22:0] pn23_next(input logic [22:0] s);
    logic fb = s[22] ^ s[17];
    return (s << 1) | 23'(fb);
  endfunction

  function automatic logic [11:0] expect_word(input logic [3:0] m, input logic [1:0] s,
                                              input int i, input logic [11:0] d,
                                              input logic [11:0] a, input logic [11:0] b,
                                              input logic [8:0] p9, input logic [22:0] p23);
    case (m)
      4'd1:  return 12'h800;
      4'd2:  return 12'hFFF;
      4'd3:  return 12'h000;
      4'd4:  return (i % 2) ? 12'h555 : 12'hAAA;
      4'd5:  return p23[22:11];
      4'd6:  return {3'b000, p9};
      4'd7:  return (i % 2) ? 12'hFFF : 12'h000;
      4'd8: begin
        case (s)
          2'b00: return a;
          2'b01: return (i % 2) ? b : a;
          2'b10: return (i >= 1) ? d : a;
          default: return (i >= 2) ? d : ((i == 1) ? b : a);
        endcase
      end
      4'd9:  return (i % 2) ? 12'h001 : 12'h000;
      4'd10: return 12'hF00;
      4'd11: return 12'h800;
      4'd12: return 12'(i % 4096);
      default: return d;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m, input logic [1:0] s);
    case (m)
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11: return "R2";
      4'd4, 4'd7, 4'd9: return "R3";
      4'd12: return "R4";
      4'd6:  return "R5";
      4'd5:  return "R6";
      4'd8:  return s[1] ? "R8" : "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid/data %h, expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // One clock cycle: model, edge, compare; inputs set before the call.
  task automatic cyc();
    string req = "R1";
    logic  exp_v = smp_en;
    if (smp_en) begin
      int i = ((mode_sel != m_mode) || (user_seq != m_seq)) ? 0 : m_idx;
      m_out  = expect_word(mode_sel, user_seq, i, in_data, user_a, user_b, m_pn9, m_pn23);
      req    = req_of(mode_sel, user_seq);
      m_idx  = i + 1;
      m_mode = mode_sel;
      m_seq  = user_seq;
    end
    if (pn_short_rst) m_pn9 = 9'h1FF;
    else if (smp_en && mode_sel == 4'd6) m_pn9 = pn9_next(m_pn9);
    if (pn_long_rst) m_pn23 = 23'h7FFFFF;
    else if (smp_en && mode_sel == 4'd5) m_pn23 = pn23_next(m_pn23);
    @(posedge clk);
    #1;
    check(req, {out_valid, out_data}, {exp_v, m_out});
  endtask

  task automatic run_mode(input logic [3:0] m, input logic [1:0] s, input int n);
    mode_sel = m;
    user_seq = s;
    for (int k = 0; k < n; k++) begin
      smp_en  = 1'b1;
      in_data = 12'($urandom);
      cyc();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9", {out_valid, out_data}, 13'h0000);
    rst_n = 1'b1;
    #1;
    check("R9", {out_valid, out_data}, 13'h0000);

    // R1 pass-through, idle hold, unused codes
    run_mode(4'd0, 2'b00, 4);
    smp_en = 1'b0; in_data = 12'h123; cyc(); cyc();
    run_mode(4'd14, 2'b00, 3);
    // R2 constants
    run_mode(4'd1, 2'b00, 2); run_mode(4'd2, 2'b00, 2); run_mode(4'd3, 2'b00, 2);
    run_mode(4'd10, 2'b00, 2); run_mode(4'd11, 2'b00, 2);
    // R3 alternating patterns, restart on re-entry
    run_mode(4'd4, 2'b00, 5); run_mode(4'd7, 2'b00, 4); run_mode(4'd9, 2'b00, 4);
    run_mode(4'd4, 2'b00, 3);
    // R4 counting pattern with a gap mid-way
    run_mode(4'd12, 2'b00, 6);
    smp_en = 1'b0; cyc();
    run_mode(4'd12, 2'b00, 4);
    // R5 short generator: hold, release, run
    pn_short_rst = 1'b1; run_mode(4'd6, 2'b00, 3);
    pn_short_rst = 1'b0; run_mode(4'd6, 2'b00, 40);
    // R6 long generator
    pn_long_rst = 1'b1; run_mode(4'd5, 2'b00, 2);
    pn_long_rst = 1'b0; run_mode(4'd5, 2'b00, 40);
    // R7 / R8 user words
    user_a = 12'h3C5; user_b = 12'hA0F;
    run_mode(4'd8, 2'b00, 3); run_mode(4'd8, 2'b01, 5);
    run_mode(4'd8, 2'b10, 4); run_mode(4'd8, 2'b11, 5);
    run_mode(4'd0, 2'b00, 1); run_mode(4'd8, 2'b11, 4);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 39) == 0) begin
        mode_sel = 4'($urandom);
        user_seq = 2'($urandom);
      end
      if ($urandom_range(0, 99) == 0) user_a = 12'($urandom);
      if ($urandom_range(0, 99) == 0) user_b = 12'($urandom);
      pn_short_rst = ($urandom_range(0, 59) == 0);
      pn_long_rst  = ($urandom_range(0, 59) == 0);
      smp_en  = ($urandom_range(0, 3) != 0);
      in_data = 12'($urandom);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule